// File: doc/BRIEF.md
# Register Sidecar Bounds Checker

This block checks memory accesses against small caches of permission information, one attached to each general register and one attached to the program counter. Each of these sidecars holds a region start, a region end and a two-bit permission. For each access, the block adds the source register value to the immediate to form the effective address. It then tests that address against the selected sidecar's range and compares the access type with the stored permission. One cycle later it reports either that the access may proceed or that the sidecar missed.

A miss is not a final denial. The miss output, together with the address, access kind and sidecar slot, forms the request that goes to the protection lookaside buffer. That buffer lies outside this block. When it returns a region, the fill port loads the region into the slot that missed. Regions may start and end on any address, so a region need not be a power of two in size or aligned.

Writing a general register invalidates its sidecar. A global clear empties every sidecar, including the one for the program counter, when the protection domain changes or when permissions are revoked.

Top module: `sidecar_guard`

## Requirements
- R1: The effective address is `req_base + req_imm` modulo 2^AW. It appears on `out_addr` in the cycle after the request is sampled.
- R2: Loads (kind 0) and stores (kind 1) use the sidecar of general register `req_reg`, which is slot `req_reg`. Fetches (kind 2) use the program counter sidecar, which is slot NREG, whatever `req_reg` holds. The slot used appears on `out_slot`.
- R3: An address hits only when start <= address < end, compared as unsigned values. Any start and end values are accepted, with no alignment or power-of-two rule. An address outside the range gives a miss.
- R4: Permission codes are 0 = none, 1 = read only, 2 = read/write and 3 = execute/read. A load is allowed by codes 1, 2 or 3. A store is allowed only by code 2. A fetch is allowed only by code 3. Kind 3 is never allowed. A denied permission gives a miss.
- R5: The result appears exactly one cycle after `req_valid` is sampled. When `out_valid` is high, exactly one of `out_allow` and `out_miss` is high. When `out_valid` is low, both are low.
- R6: After reset every sidecar is empty, so every access misses.
- R7: `fill_valid` loads the start, end and permission into slot `fill_slot`. A request sampled at the same edge still sees the old contents. Requests from the next edge on see the new region.
- R8: `wr_valid` empties the sidecar of general register `wr_reg`. It wins over a fill to the same slot at the same edge. It never touches the program counter sidecar.
- R9: `flush_all` empties every sidecar, including the program counter sidecar, and wins over a fill at the same edge.
- R10: With every result, `out_kind` and `out_slot` carry the access kind and the slot used, so that a miss can be forwarded and refilled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 reserved |
| req_reg | input | $clog2(NREG) | Source general register index |
| req_base | input | AW | Source register value (the PC value for fetches) |
| req_imm | input | AW | Immediate, already sign-extended |
| fill_valid | input | 1 | Refill from the lookaside buffer |
| fill_slot | input | $clog2(NREG+1) | Slot to load (NREG selects the PC sidecar) |
| fill_lo | input | AW | Region start, inclusive |
| fill_hi | input | AW | Region end, exclusive |
| fill_perm | input | 2 | Region permission code |
| wr_valid | input | 1 | General register written |
| wr_reg | input | $clog2(NREG) | Index of the written register |
| flush_all | input | 1 | Empty all sidecars |
| out_valid | output | 1 | Result present |
| out_allow | output | 1 | Access may proceed |
| out_miss | output | 1 | Forward the access to the lookaside buffer |
| out_addr | output | AW | Effective address |
| out_kind | output | 2 | Access kind of the result |
| out_slot | output | $clog2(NREG+1) | Sidecar slot used |

## Verification
The assertions assume that `req_reg` and `wr_reg` are below NREG. They also assume that the inputs keep their inactive values while reset is low, because several properties look one cycle back.

The bench drives every input at the falling edge and keeps each index inside its legal range. It holds all strobes low during reset. Random regions are kept small and close to the random addresses, so hits, edge misses and permission denials all occur often.

// File: rtl/sgc_pkg.sv
// Package sgc_pkg: shared permission and access-kind encodings for the sidecar checker.
// Assumes two-bit codes throughout; kind 3 is reserved and never allowed.
package sgc_pkg;

    typedef enum logic [1:0] {
        PERM_NONE = 2'd0,
        PERM_RD   = 2'd1,
        PERM_RW   = 2'd2,
        PERM_XR   = 2'd3
    } perm_e;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    // Decide whether a permission code grants an access kind.
    function automatic logic perm_grants(input logic [1:0] perm, input logic [1:0] kind);
        logic ok;
        case (acc_e'(kind))
            ACC_LOAD:  ok = (perm_e'(perm) != PERM_NONE);
            ACC_STORE: ok = (perm_e'(perm) == PERM_RW);
            ACC_FETCH: ok = (perm_e'(perm) == PERM_XR);
            default:   ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/sgc_addr_unit.sv
// Module sgc_addr_unit: forms the effective address from a register value and an immediate.
// Assumes the immediate is already sign-extended to AW bits; the sum wraps modulo 2^AW.
module sgc_addr_unit #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] reg_val,
    input  logic [AW-1:0] imm_val,
    output logic [AW-1:0] eff_addr
);

    // Plain wrapping add, no carry out is kept.
    always_comb begin
        eff_addr = reg_val + imm_val;
    end

endmodule

// File: rtl/sgc_bank.sv
// Module sgc_bank: storage for NSLOT sidecars (valid, start, end, permission) with one read port.
// Assumes clear-all has priority over a register-write invalidate, which has priority over a fill.
// Writes take effect at the clock edge; the read port shows the contents before that edge.
module sgc_bank #(
    parameter int NSLOT = 9,
    parameter int AW    = 32,
    localparam int SW   = $clog2(NSLOT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] rd_slot,
    output logic          rd_vld,
    output logic [AW-1:0] rd_lo,
    output logic [AW-1:0] rd_hi,
    output logic [1:0]    rd_perm,
    input  logic          fill_en,
    input  logic [SW-1:0] fill_slot,
    input  logic [AW-1:0] fill_lo,
    input  logic [AW-1:0] fill_hi,
    input  logic [1:0]    fill_perm,
    input  logic          kill_en,
    input  logic [SW-1:0] kill_slot,
    input  logic          clear_all
);

    logic [NSLOT-1:0] vld_a;
    logic [AW-1:0]    lo_a   [NSLOT];
    logic [AW-1:0]    hi_a   [NSLOT];
    logic [1:0]       perm_a [NSLOT];

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        logic          v_q;
        logic [AW-1:0] lo_q;
        logic [AW-1:0] hi_q;
        logic [1:0]    p_q;
        logic          fill_hit;
        logic          kill_hit;

        assign fill_hit = fill_en && (fill_slot == SW'(g));
        assign kill_hit = kill_en && (kill_slot == SW'(g));

        // Update one sidecar: clear, invalidate or load in priority order.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q  <= 1'b0;
                lo_q <= '0;
                hi_q <= '0;
                p_q  <= 2'd0;
            end else if (clear_all || kill_hit) begin
                v_q <= 1'b0;
            end else if (fill_hit) begin
                v_q  <= 1'b1;
                lo_q <= fill_lo;
                hi_q <= fill_hi;
                p_q  <= fill_perm;
            end
        end

        assign vld_a[g]  = v_q;
        assign lo_a[g]   = lo_q;
        assign hi_a[g]   = hi_q;
        assign perm_a[g] = p_q;
    end

    // Select the sidecar addressed by the read port.
    always_comb begin
        rd_vld  = 1'b0;
        rd_lo   = '0;
        rd_hi   = '0;
        rd_perm = 2'd0;
        for (int i = 0; i < NSLOT; i++) begin
            if (rd_slot == SW'(i)) begin
                rd_vld  = vld_a[i];
                rd_lo   = lo_a[i];
                rd_hi   = hi_a[i];
                rd_perm = perm_a[i];
            end
        end
    end

endmodule

// File: rtl/sgc_judge.sv
// Module sgc_judge: decides hit or miss for one address against one sidecar.
// Assumes an unsigned range with an inclusive start and an exclusive end; an empty sidecar always misses.
module sgc_judge #(
    parameter int AW = 32
) (
    input  logic          sc_vld,
    input  logic [AW-1:0] sc_lo,
    input  logic [AW-1:0] sc_hi,
    input  logic [1:0]    sc_perm,
    input  logic [AW-1:0] addr,
    input  logic [1:0]    kind,
    output logic          allow
);
    import sgc_pkg::*;

    logic in_range;
    logic grants;

    // Range compare and permission decode, combined into the hit decision.
    always_comb begin
        in_range = (addr >= sc_lo) && (addr < sc_hi);
        grants   = perm_grants(sc_perm, kind);
        allow    = sc_vld && in_range && grants;
    end

endmodule

// File: rtl/sidecar_guard.sv
// Module sidecar_guard: per-register sidecar permission check with a one-cycle result.
// Slots 0..NREG-1 belong to the general registers and slot NREG to the program counter.
// Assumes req_reg and wr_reg are below NREG. A miss is forwarded by the caller to the
// lookaside buffer, whose answer comes back on the fill port.
module sidecar_guard #(
    parameter int NREG = 8,
    parameter int AW   = 32,
    localparam int RW    = $clog2(NREG),
    localparam int NSLOT = NREG + 1,
    localparam int SW    = $clog2(NSLOT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_kind,
    input  logic [RW-1:0] req_reg,
    input  logic [AW-1:0] req_base,
    input  logic [AW-1:0] req_imm,
    input  logic          fill_valid,
    input  logic [SW-1:0] fill_slot,
    input  logic [AW-1:0] fill_lo,
    input  logic [AW-1:0] fill_hi,
    input  logic [1:0]    fill_perm,
    input  logic          wr_valid,
    input  logic [RW-1:0] wr_reg,
    input  logic          flush_all,
    output logic          out_valid,
    output logic          out_allow,
    output logic          out_miss,
    output logic [AW-1:0] out_addr,
    output logic [1:0]    out_kind,
    output logic [SW-1:0] out_slot
);
    import sgc_pkg::*;

    logic [AW-1:0] eff_addr;
    logic [SW-1:0] sel_slot;
    logic [SW-1:0] kill_slot;
    logic          sc_vld;
    logic [AW-1:0] sc_lo;
    logic [AW-1:0] sc_hi;
    logic [1:0]    sc_perm;
    logic          hit;

    // Fetches use the program counter slot; other kinds use the source register's slot.
    always_comb begin
        if (acc_e'(req_kind) == ACC_FETCH) sel_slot = SW'(NREG);
        else                              sel_slot = SW'(req_reg);
        kill_slot = SW'(wr_reg);
    end

    sgc_addr_unit #(.AW(AW)) i_addr (
        .reg_val  (req_base),
        .imm_val  (req_imm),
        .eff_addr (eff_addr)
    );

    sgc_bank #(.NSLOT(NSLOT), .AW(AW)) i_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_slot   (sel_slot),
        .rd_vld    (sc_vld),
        .rd_lo     (sc_lo),
        .rd_hi     (sc_hi),
        .rd_perm   (sc_perm),
        .fill_en   (fill_valid),
        .fill_slot (fill_slot),
        .fill_lo   (fill_lo),
        .fill_hi   (fill_hi),
        .fill_perm (fill_perm),
        .kill_en   (wr_valid),
        .kill_slot (kill_slot),
        .clear_all (flush_all)
    );

    sgc_judge #(.AW(AW)) i_judge (
        .sc_vld  (sc_vld),
        .sc_lo   (sc_lo),
        .sc_hi   (sc_hi),
        .sc_perm (sc_perm),
        .addr    (eff_addr),
        .kind    (req_kind),
        .allow   (hit)
    );

    // Register the decision together with the address, kind and slot for forwarding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_allow <= 1'b0;
            out_miss  <= 1'b0;
            out_addr  <= '0;
            out_kind  <= 2'd0;
            out_slot  <= '0;
        end else begin
            out_valid <= req_valid;
            out_allow <= req_valid && hit;
            out_miss  <= req_valid && !hit;
            if (req_valid) begin
                out_addr <= eff_addr;
                out_kind <= req_kind;
                out_slot <= sel_slot;
            end
        end
    end

endmodule

// File: rtl/sidecar_guard_sva.sv
// Module sidecar_guard_sva: temporal checks on sidecar_guard, attached by bind below.
// Assumes inputs keep their idle values while reset is low.
module sidecar_guard_sva #(
    parameter int NREG = 8,
    parameter int AW   = 32,
    localparam int RW    = $clog2(NREG),
    localparam int SW    = $clog2(NREG + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [1:0]    req_kind,
    input logic [RW-1:0] req_reg,
    input logic [AW-1:0] req_base,
    input logic [AW-1:0] req_imm,
    input logic          fill_valid,
    input logic [SW-1:0] fill_slot,
    input logic [AW-1:0] fill_lo,
    input logic [AW-1:0] fill_hi,
    input logic [1:0]    fill_perm,
    input logic          wr_valid,
    input logic [RW-1:0] wr_reg,
    input logic          flush_all,
    input logic          out_valid,
    input logic          out_allow,
    input logic          out_miss,
    input logic [AW-1:0] out_addr,
    input logic [1:0]    out_kind,
    input logic [SW-1:0] out_slot
);

    logic [AW-1:0] chk_addr;
    assign chk_addr = req_base + req_imm;

    a_r5_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_allow != out_miss));

    a_r5_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_allow && !out_miss));

    a_r5_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    a_r1_address: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (out_addr == $past(chk_addr)));

    a_r2_pc_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd2) |=> (out_slot == SW'(NREG)));

    a_r10_kind_echo: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (out_kind == $past(req_kind)));

    a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flush_all) && req_valid) |=> out_miss);

    a_r8_write_empties: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_valid) && req_valid && req_kind != 2'd2 && req_reg == $past(wr_reg))
        |=> out_miss);

    // R7 with R3: a fresh read-only region answers a load at its first address.
    a_r7_fill_visible: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fill_valid) && !$past(flush_all)
         && !($past(wr_valid) && SW'($past(wr_reg)) == $past(fill_slot))
         && !(wr_valid && wr_reg == req_reg)
         && $past(fill_perm) != 2'd0 && $past(fill_lo) < $past(fill_hi)
         && req_valid && req_kind == 2'd0 && SW'(req_reg) == $past(fill_slot)
         && chk_addr == $past(fill_lo))
        |=> out_allow);

endmodule

bind sidecar_guard sidecar_guard_sva #(.NREG(NREG), .AW(AW)) i_sidecar_guard_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_kind   (req_kind),
    .req_reg    (req_reg),
    .req_base   (req_base),
    .req_imm    (req_imm),
    .fill_valid (fill_valid),
    .fill_slot  (fill_slot),
    .fill_lo    (fill_lo),
    .fill_hi    (fill_hi),
    .fill_perm  (fill_perm),
    .wr_valid   (wr_valid),
    .wr_reg     (wr_reg),
    .flush_all  (flush_all),
    .out_valid  (out_valid),
    .out_allow  (out_allow),
    .out_miss   (out_miss),
    .out_addr   (out_addr),
    .out_kind   (out_kind),
    .out_slot   (out_slot)
);

// File: tb/test_sidecar_guard.sv
`timescale 1ns/1ps
// Bench test_sidecar_guard: directed corner cases followed by seeded random traffic,
// compared against a behavioural model of the sidecars kept in the bench.
module test_sidecar_guard;
    localparam int NREG  = 8;
    localparam int AW    = 32;
    localparam int RW    = $clog2(NREG);
    localparam int NSLOT = NREG + 1;
    localparam int SW    = $clog2(NSLOT);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_kind = '0;
    logic [RW-1:0] req_reg = '0;
    logic [AW-1:0] req_base = '0;
    logic [AW-1:0] req_imm = '0;
    logic          fill_valid = 1'b0;
    logic [SW-1:0] fill_slot = '0;
    logic [AW-1:0] fill_lo = '0;
    logic [AW-1:0] fill_hi = '0;
    logic [1:0]    fill_perm = '0;
    logic          wr_valid = 1'b0;
    logic [RW-1:0] wr_reg = '0;
    logic          flush_all = 1'b0;
    logic          out_valid;
    logic          out_allow;
    logic          out_miss;
    logic [AW-1:0] out_addr;
    logic [1:0]    out_kind;
    logic [SW-1:0] out_slot;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Model of the sidecars.
    bit            m_v  [NSLOT];
    logic [AW-1:0] m_lo [NSLOT];
    logic [AW-1:0] m_hi [NSLOT];
    logic [1:0]    m_p  [NSLOT];

    // Pending expectation for the result of the last driven cycle.
    bit            e_valid = 1'b0;
    bit            e_allow;
    logic [AW-1:0] e_addr;
    logic [1:0]    e_kind;
    logic [SW-1:0] e_slot;
    string         e_tag = "R5";

    always #10 clk = ~clk;

    sidecar_guard #(.NREG(NREG), .AW(AW)) i_sidecar_guard (.*);

    function automatic bit exp_grant(input logic [1:0] p, input logic [1:0] k);
        case (k)
            2'd0:    return p != 2'd0;
            2'd1:    return p == 2'd2;
            2'd2:    return p == 2'd3;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input bit cond, input string tag, input string what,
                         input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_tests++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Check the previous cycle's result, drive one cycle, then update the model.
    task automatic step(input bit rv, input logic [1:0] k, input logic [RW-1:0] r,
                        input logic [AW-1:0] b, input logic [AW-1:0] im,
                        input bit fv, input logic [SW-1:0] fs, input logic [AW-1:0] flo,
                        input logic [AW-1:0] fhi, input logic [1:0] fp,
                        input bit wv, input logic [RW-1:0] wr, input bit fl,
                        input string tag);
        int s;
        @(negedge clk);
        check(out_valid == e_valid, "R5", "out_valid", AW'(out_valid), AW'(e_valid));
        if (e_valid) begin
            check(out_allow == e_allow, e_tag, "out_allow", AW'(out_allow), AW'(e_allow));
            check(out_miss == !e_allow, e_tag, "out_miss", AW'(out_miss), AW'(!e_allow));
            check(out_addr == e_addr, "R1", "out_addr", out_addr, e_addr);
            check(out_slot == e_slot, "R2", "out_slot", AW'(out_slot), AW'(e_slot));
            check(out_kind == e_kind, "R10", "out_kind", AW'(out_kind), AW'(e_kind));
        end else begin
            check(!out_allow && !out_miss, "R5", "idle outcome", AW'({out_allow, out_miss}), '0);
        end
        req_valid = rv; req_kind = k; req_reg = r; req_base = b; req_imm = im;
        fill_valid = fv; fill_slot = fs; fill_lo = flo; fill_hi = fhi; fill_perm = fp;
        wr_valid = wv; wr_reg = wr; flush_all = fl;
        e_valid = rv;
        if (rv) begin
            s      = (k == 2'd2) ? NREG : int'(r);
            e_addr = b + im;
            e_kind = k;
            e_slot = SW'(s);
            e_allow = m_v[s] && (e_addr >= m_lo[s]) && (e_addr < m_hi[s]) && exp_grant(m_p[s], k);
            e_tag  = tag;
        end
        if (fv && int'(fs) < NSLOT) begin
            m_v[fs] = 1'b1; m_lo[fs] = flo; m_hi[fs] = fhi; m_p[fs] = fp;
        end
        if (wv) m_v[wr] = 1'b0;
        if (fl) for (int i = 0; i < NSLOT; i++) m_v[i] = 1'b0;
    endtask

    task automatic req(input logic [1:0] k, input logic [RW-1:0] r, input logic [AW-1:0] b,
                       input logic [AW-1:0] im, input string tag);
        step(1, k, r, b, im, 0, '0, '0, '0, '0, 0, '0, 0, tag);
    endtask

    task automatic fill(input logic [SW-1:0] fs, input logic [AW-1:0] flo,
                        input logic [AW-1:0] fhi, input logic [1:0] fp, input string tag);
        step(0, '0, '0, '0, '0, 1, fs, flo, fhi, fp, 0, '0, 0, tag);
    endtask

    initial begin
        for (int i = 0; i < NSLOT; i++) begin
            m_v[i] = 1'b0; m_lo[i] = '0; m_hi[i] = '0; m_p[i] = '0;
        end
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0 && out_allow == 1'b0 && out_miss == 1'b0, "R5",
              "reset outputs", AW'({out_valid, out_allow, out_miss}), '0);
        rst_n = 1'b1;

        // R6: every slot empty after reset.
        for (int r = 0; r < NREG; r++) req(2'd0, RW'(r), 32'h100, 32'h0, "R6");
        req(2'd2, '0, 32'h100, 32'h0, "R6");

        // R3 and R7: five-byte read-only region, edges of the range.
        fill(SW'(2), 32'h100, 32'h105, 2'd1, "R7");
        req(2'd0, RW'(2), 32'h100, 32'h0, "R7");
        req(2'd0, RW'(2), 32'h100, 32'h4, "R3");
        req(2'd0, RW'(2), 32'h100, 32'h5, "R3");
        req(2'd0, RW'(2), 32'h100, 32'hFFFF_FFFF, "R3");
        req(2'd1, RW'(2), 32'h102, 32'h0, "R4");
        req(2'd2, RW'(2), 32'h102, 32'h0, "R2");
        req(2'd3, RW'(2), 32'h102, 32'h0, "R4");

        // R7: a request at the same edge as its fill sees the old contents.
        step(1, 2'd0, RW'(5), 32'h40, 32'h0, 1, SW'(5), 32'h40, 32'h41, 2'd2, 0, '0, 0, "R7");
        req(2'd0, RW'(5), 32'h40, 32'h0, "R7");
        req(2'd1, RW'(5), 32'h40, 32'h0, "R4");

        // R2 and R4: program counter slot against execute and read/write codes.
        fill(SW'(NREG), 32'h200, 32'h300, 2'd3, "R2");
        fill(SW'(0), 32'h200, 32'h300, 2'd2, "R4");
        req(2'd2, RW'(0), 32'h250, 32'h0, "R2");
        req(2'd2, RW'(0), 32'h2F0, 32'h10, "R3");
        req(2'd0, RW'(0), 32'h250, 32'h0, "R4");
        req(2'd1, RW'(0), 32'h250, 32'h0, "R4");
        req(2'd0, RW'(1), 32'h250, 32'h0, "R2");

        // R1: the effective address wraps around.
        fill(SW'(3), 32'h0, 32'h10, 2'd2, "R1");
        req(2'd0, RW'(3), 32'hFFFF_FFF8, 32'h10, "R1");

        // R8: a register write empties only its own slot and never the PC slot.
        step(0, '0, '0, '0, '0, 0, '0, '0, '0, '0, 1, RW'(3), 0, "R8");
        req(2'd0, RW'(3), 32'h8, 32'h0, "R8");
        step(0, '0, '0, '0, '0, 0, '0, '0, '0, '0, 1, RW'(0), 0, "R8");
        req(2'd2, RW'(0), 32'h250, 32'h0, "R8");
        req(2'd0, RW'(0), 32'h250, 32'h0, "R8");
        step(0, '0, '0, '0, '0, 1, SW'(3), 32'h0, 32'h10, 2'd2, 1, RW'(3), 0, "R8");
        req(2'd0, RW'(3), 32'h8, 32'h0, "R8");

        // R9: clear everything, including a fill at the same edge.
        fill(SW'(4), 32'h10, 32'h20, 2'd2, "R9");
        step(0, '0, '0, '0, '0, 1, SW'(6), 32'h10, 32'h20, 2'd2, 0, '0, 1, "R9");
        req(2'd0, RW'(4), 32'h10, 32'h0, "R9");
        req(2'd0, RW'(6), 32'h10, 32'h0, "R9");
        req(2'd2, RW'(0), 32'h250, 32'h0, "R9");
        step(0, '0, '0, '0, '0, 0, '0, '0, '0, '0, 0, '0, 0, "R5");

        // Random mix of requests, fills, writes and rare clears.
        for (int n = 0; n < 4000; n++) begin
            logic [AW-1:0] lo;
            lo = AW'($urandom_range(0, 32'h3FF));
            step($urandom_range(0, 3) != 0, 2'($urandom_range(0, 3)), RW'($urandom_range(0, NREG-1)),
                 AW'($urandom_range(0, 32'h4FF)), AW'($urandom_range(0, 32'h3F)) - 32'h20,
                 $urandom_range(0, 2) == 0, SW'($urandom_range(0, NREG)), lo,
                 lo + AW'($urandom_range(1, 300)), 2'($urandom_range(0, 3)),
                 $urandom_range(0, 9) == 0, RW'($urandom_range(0, NREG-1)),
                 $urandom_range(0, 199) == 0, "R3");
        end
        step(0, '0, '0, '0, '0, 0, '0, '0, '0, '0, 0, '0, 0, "R5");
        step(0, '0, '0, '0, '0, 0, '0, '0, '0, '0, 0, '0, 0, "R5");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule